// File: doc/BRIEF.md
# Decode Stall Controller With Retry Slot

This block decides, every cycle, which instructions of an out-of-order front end's decode group may enter the back end. It tracks four resource budgets presented as free counts: rename registers, active-list entries, branch checkpoint maps and memory-queue entries. It hands these out to a group of up to `W` instructions in slot order and reports how much of each it used. An instruction that was decoded but cannot get everything it needs is held in a single-entry retry slot. The controller then raises a stop flag that keeps the decode stage from accepting anything new.

Each cycle the held instruction is offered the resources before any new slot. New slots are considered only once it has gone through. Branch information carried with each slot shapes the group. A branch predicted taken ends the group. The slot after a predicted delayed branch needs a checkpoint map, and this need carries over into the next cycle when the branch is the last slot. A branch left unpredicted stops decode until the front end is flushed. The stop comes right after the branch when the branch annuls or has no delay slot, and after its delay slot otherwise. A synchronous flush, used on a misprediction or trap, empties the retry slot and clears every stop.

Top module: `decode_stall_ctrl`

## Requirements
- R1: While the retry slot is occupied, its instruction is offered resources first. If it cannot get them, no new slot is taken that cycle. If it gets them, `retry_go` is 1, its usage is counted in the `*_used` outputs, and new slots may be decoded in the same cycle from what remains.
- R2: A slot is parked when it needs more rename registers (`in_dst` field, 2 bits per slot, slot i at bits [2i+1:2i]) than remain, or when no active-list entry remains (each instruction uses one). A parked slot is marked in `slot_taken` but not in `slot_dispatch`. No later slot is taken that cycle. From the next cycle `buf_valid` and `stop` are 1. At most one slot is parked per cycle.
- R3: When the held instruction is dispatched and no unpredicted-branch stop is pending, `stop` returns to 0 in the next cycle. From then on, only the outcome of newly decoded slots can raise it again.
- R4: A branch (`in_br`=1) predicted (`in_unpred`=0) as taken (`in_taken`=1) is the last slot taken in its cycle. Decode resumes normally in the next cycle.
- R5: The slot that follows a predicted delayed branch (`in_delayed`=1) needs one checkpoint map. With none free, it is parked. This need carries into the next cycle's first slot when the branch was the last slot taken.
- R6: An unpredicted branch that annuls (`in_annul`=1) or is not delayed is the last slot taken. An unpredicted delayed branch that does not annul lets exactly one more slot through, in this cycle or the next. After that, `stop` stays 1 and no slot is taken until a flush.
- R7: A memory slot (`in_mem`=1) that finds no memory-queue entry is parked when `static_mode` is 1. When `static_mode` is 0 it is dispatched with its `slot_ovf` bit set and uses no memory-queue entry.
- R8: Resources are handed out cumulatively in slot order. Each `*_used` output equals the sum used by the retry and the dispatched slots, and never exceeds the matching free count.
- R9: A cycle with `flush` high takes no slot and dispatches no retry. In the next cycle `buf_valid` and `stop` are 0 and no checkpoint need is pending.
- R10: The taken slots always form a prefix starting at slot 0. The first slot with `in_valid`=0 ends the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Synchronous front-end flush |
| static_mode | input | 1 | 1: full memory queue stalls decode; 0: overflow queue used |
| in_valid | input | W | Slot holds an instruction |
| in_dst | input | W*DW | Rename registers needed per slot |
| in_br | input | W | Slot is a branch |
| in_taken | input | W | Branch predicted taken |
| in_delayed | input | W | Branch has a delay slot |
| in_annul | input | W | Branch may annul its delay slot |
| in_unpred | input | W | Branch was not predicted |
| in_mem | input | W | Slot is a memory operation |
| free_regs | input | CW | Free rename registers |
| free_al | input | CW | Free active-list entries |
| free_shadow | input | CW | Free checkpoint maps |
| free_memq | input | CW | Free memory-queue entries |
| slot_taken | output | W | Slot consumed by decode (dispatched or parked) |
| slot_dispatch | output | W | Slot entered the back end |
| slot_ovf | output | W | Dispatched slot went to the memory overflow queue |
| retry_go | output | 1 | Held instruction dispatched this cycle |
| retry_ovf | output | 1 | Held instruction went to the overflow queue |
| buf_valid | output | 1 | Retry slot occupied |
| stop | output | 1 | Decode blocked at the start of this cycle |
| regs_used | output | CW | Rename registers granted this cycle |
| al_used | output | CW | Active-list entries granted this cycle |
| shadow_used | output | CW | Checkpoint maps granted this cycle |
| memq_used | output | CW | Memory-queue entries granted this cycle |

## Verification
Groups of four plain slots are swept through every combination of register demands, against every rename budget from zero to seven and several active-list budgets. Each case is predicted by summing prefix demands. This separates off-by-one budget comparisons, wrong cumulative accounting and wrong cut points in the group. Directed sequences then exercise the retry slot: a retry that fails, then one that succeeds while later slots in the same group fail. These tell apart retry-first ordering from plain slot ordering. Branch sequences are placed mid-group and in the last slot. They separate same-cycle effects from effects carried into the next cycle. The memory cases run under both scheduling modes and tell parking apart from overflow dispatch.

// File: rtl/decode_stall_ctrl.sv
module decode_stall_ctrl #(
  parameter int W  = 4,
  parameter int CW = 4,
  parameter int DW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            static_mode,
  input  logic [W-1:0]    in_valid,
  input  logic [W*DW-1:0] in_dst,
  input  logic [W-1:0]    in_br,
  input  logic [W-1:0]    in_taken,
  input  logic [W-1:0]    in_delayed,
  input  logic [W-1:0]    in_annul,
  input  logic [W-1:0]    in_unpred,
  input  logic [W-1:0]    in_mem,
  input  logic [CW-1:0]   free_regs,
  input  logic [CW-1:0]   free_al,
  input  logic [CW-1:0]   free_shadow,
  input  logic [CW-1:0]   free_memq,
  output logic [W-1:0]    slot_taken,
  output logic [W-1:0]    slot_dispatch,
  output logic [W-1:0]    slot_ovf,
  output logic            retry_go,
  output logic            retry_ovf,
  output logic            buf_valid,
  output logic            stop,
  output logic [CW-1:0]   regs_used,
  output logic [CW-1:0]   al_used,
  output logic [CW-1:0]   shadow_used,
  output logic [CW-1:0]   memq_used
);

  logic          buf_q, hold_q, pend_sh_q, pend_hold_q;
  logic [DW-1:0] buf_dst_q;
  logic          buf_mem_q, buf_sh_q;

  logic          park, park_mem, park_sh;
  logic [DW-1:0] park_dst;
  logic          hold_n, sh_n, hd_n;
  logic [CW-1:0] r_reg, r_al, r_sh, r_mq;

  always_comb begin
    logic          go, ok, full, br_p, br_u;
    logic [DW-1:0] d;
    r_reg = free_regs;
    r_al  = free_al;
    r_sh  = free_shadow;
    r_mq  = free_memq;
    slot_taken    = '0;
    slot_dispatch = '0;
    slot_ovf      = '0;
    retry_go  = 1'b0;
    retry_ovf = 1'b0;
    park      = 1'b0;
    park_dst  = '0;
    park_mem  = 1'b0;
    park_sh   = 1'b0;
    hold_n    = hold_q;
    sh_n      = pend_sh_q;
    hd_n      = pend_hold_q;
    go        = !flush && !hold_q;
    ok        = 1'b0;
    full      = 1'b0;
    br_p      = 1'b0;
    br_u      = 1'b0;
    d         = '0;

    if (!flush && buf_q) begin
      full = buf_mem_q && (r_mq == '0);
      ok   = (CW'(buf_dst_q) <= r_reg) && (r_al != '0) &&
             (!buf_sh_q || r_sh != '0) && !(full && static_mode);
      if (ok) begin
        retry_go  = 1'b1;
        retry_ovf = full;
        r_reg = r_reg - CW'(buf_dst_q);
        r_al  = r_al - CW'(1);
        if (buf_sh_q) r_sh = r_sh - CW'(1);
        if (buf_mem_q && !full) r_mq = r_mq - CW'(1);
      end else begin
        go = 1'b0;
      end
    end

    for (int i = 0; i < W; i++) begin
      if (go && in_valid[i]) begin
        d    = in_dst[i*DW +: DW];
        slot_taken[i] = 1'b1;
        full = in_mem[i] && (r_mq == '0);
        ok   = (CW'(d) <= r_reg) && (r_al != '0) &&
               (!sh_n || r_sh != '0) && !(full && static_mode);
        if (ok) begin
          slot_dispatch[i] = 1'b1;
          slot_ovf[i]      = full;
          r_reg = r_reg - CW'(d);
          r_al  = r_al - CW'(1);
          if (sh_n) r_sh = r_sh - CW'(1);
          if (in_mem[i] && !full) r_mq = r_mq - CW'(1);
        end else begin
          park     = 1'b1;
          park_dst = d;
          park_mem = in_mem[i];
          park_sh  = sh_n;
          go       = 1'b0;
        end
        if (hd_n) begin
          hold_n = 1'b1;
          go     = 1'b0;
        end
        br_p = in_br[i] && !in_unpred[i];
        br_u = in_br[i] && in_unpred[i];
        sh_n = br_p && in_delayed[i];
        hd_n = br_u && in_delayed[i] && !in_annul[i];
        if (br_u && (in_annul[i] || !in_delayed[i])) begin
          hold_n = 1'b1;
          go     = 1'b0;
        end
        if (br_p && in_taken[i]) go = 1'b0;
      end else begin
        go = 1'b0;
      end
    end
  end

  assign regs_used   = free_regs - r_reg;
  assign al_used     = free_al - r_al;
  assign shadow_used = free_shadow - r_sh;
  assign memq_used   = free_memq - r_mq;
  assign buf_valid   = buf_q;
  assign stop        = buf_q | hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q       <= 1'b0;
      buf_dst_q   <= '0;
      buf_mem_q   <= 1'b0;
      buf_sh_q    <= 1'b0;
      hold_q      <= 1'b0;
      pend_sh_q   <= 1'b0;
      pend_hold_q <= 1'b0;
    end else if (flush) begin
      buf_q       <= 1'b0;
      hold_q      <= 1'b0;
      pend_sh_q   <= 1'b0;
      pend_hold_q <= 1'b0;
    end else begin
      if (park) begin
        buf_q     <= 1'b1;
        buf_dst_q <= park_dst;
        buf_mem_q <= park_mem;
        buf_sh_q  <= park_sh;
      end else if (retry_go) begin
        buf_q <= 1'b0;
      end
      hold_q      <= hold_n;
      pend_sh_q   <= sh_n;
      pend_hold_q <= hd_n;
    end
  end

endmodule

// File: rtl/decode_stall_ctrl_chk.sv
module decode_stall_ctrl_chk #(
  parameter int W  = 4,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          static_mode,
  input logic [W-1:0]  slot_taken,
  input logic [W-1:0]  slot_dispatch,
  input logic [W-1:0]  slot_ovf,
  input logic          retry_go,
  input logic          buf_valid,
  input logic          stop,
  input logic [CW-1:0] free_regs,
  input logic [CW-1:0] free_al,
  input logic [CW-1:0] regs_used,
  input logic [CW-1:0] al_used
);

  p_blocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && !retry_go) |-> (slot_taken == '0));

  p_single_park_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_taken & ~slot_dispatch) <= 1);

  p_park_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(slot_taken & ~slot_dispatch)) |=> (buf_valid && stop));

  p_dispatch_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_dispatch & ~slot_taken) == '0);

  p_hold_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !buf_valid && !flush) |=> stop);

  p_ovf_dynamic_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_ovf) |-> !static_mode);

  p_budget_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_used <= free_regs) && (al_used <= free_al));

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!buf_valid && !stop));

  p_flush_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (slot_taken == '0 && !retry_go));

  p_prefix_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_taken + W'(1)) & slot_taken) == '0);

endmodule

bind decode_stall_ctrl decode_stall_ctrl_chk #(.W(W), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .static_mode(static_mode),
  .slot_taken(slot_taken), .slot_dispatch(slot_dispatch), .slot_ovf(slot_ovf),
  .retry_go(retry_go), .buf_valid(buf_valid), .stop(stop),
  .free_regs(free_regs), .free_al(free_al),
  .regs_used(regs_used), .al_used(al_used)
);

// File: tb/decode_stall_ctrl_tb_top.sv
`timescale 1ns/1ps
module decode_stall_ctrl_tb_top;
  localparam int W = 4, CW = 4, DW = 2;

  logic clk = 1'b0, rst_n = 1'b0, flush, static_mode;
  logic [W-1:0] in_valid, in_br, in_taken, in_delayed, in_annul, in_unpred, in_mem;
  logic [W*DW-1:0] in_dst;
  logic [CW-1:0] free_regs, free_al, free_shadow, free_memq;
  logic [W-1:0] slot_taken, slot_dispatch, slot_ovf;
  logic retry_go, retry_ovf, buf_valid, stop;
  logic [CW-1:0] regs_used, al_used, shadow_used, memq_used;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  decode_stall_ctrl #(.W(W), .CW(CW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .static_mode(static_mode),
    .in_valid(in_valid), .in_dst(in_dst), .in_br(in_br), .in_taken(in_taken),
    .in_delayed(in_delayed), .in_annul(in_annul), .in_unpred(in_unpred), .in_mem(in_mem),
    .free_regs(free_regs), .free_al(free_al), .free_shadow(free_shadow), .free_memq(free_memq),
    .slot_taken(slot_taken), .slot_dispatch(slot_dispatch), .slot_ovf(slot_ovf),
    .retry_go(retry_go), .retry_ovf(retry_ovf), .buf_valid(buf_valid), .stop(stop),
    .regs_used(regs_used), .al_used(al_used), .shadow_used(shadow_used), .memq_used(memq_used)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    flush = 1'b0; static_mode = 1'b1;
    in_valid = '0; in_dst = '0; in_br = '0; in_taken = '0; in_delayed = '0;
    in_annul = '0; in_unpred = '0; in_mem = '0;
    free_regs = 4'd15; free_al = 4'd15; free_shadow = 4'd15; free_memq = 4'd15;
  endtask

  task automatic next();
    @(negedge clk);
    idle();
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_flush();
    next(); flush = 1'b1; settle();
    next(); settle();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check("reset buf_valid", 32'(buf_valid), 0);
    check("reset stop", 32'(stop), 0);

    for (int code = 0; code < 256; code++) begin
      for (int fr = 0; fr < 8; fr++) begin
        int k, sum;
        next();
        in_valid = 4'hF; in_dst = 8'(code); free_regs = 4'(fr);
        k = 0; sum = 0;
        for (int j = 0; j < W; j++) begin
          if (k == j && sum + ((code >> (2*j)) & 3) <= fr) begin
            sum += (code >> (2*j)) & 3; k++;
          end
        end
        settle();
        check("R9 clear after flush", 32'({buf_valid, stop}), 0);
        check("R2 taken", 32'(slot_taken), (k == W) ? 32'hF : (32'(1) << (k+1)) - 1);
        check("R2 dispatch", 32'(slot_dispatch), (32'(1) << k) - 1);
        check("R8 regs_used", 32'(regs_used), 32'(sum));
        next(); flush = 1'b1; settle();
        if (k < W) check("R2 parked stop", 32'({buf_valid, stop}), 32'h3);
        check("R9 flush takes nothing", 32'(slot_taken), 0);
      end
    end

    for (int fa = 0; fa < 5; fa++) begin
      next(); in_valid = 4'hF; free_al = 4'(fa); settle();
      check("R2 al dispatch", 32'(slot_dispatch), (32'(1) << fa) - 1);
      check("R8 al_used", 32'(al_used), 32'(fa));
      do_flush();
    end

    next(); in_valid = 4'h1; in_dst = 8'h03; free_regs = 4'd2; settle();
    check("R2 park slot0", 32'({slot_taken, slot_dispatch}), 32'h10);
    next(); in_valid = 4'hF; in_dst = 8'h55; free_regs = 4'd2; settle();
    check("R1 retry fails blocks", 32'({retry_go, slot_taken}), 0);
    check("R1 stop held", 32'(stop), 1);
    next(); in_valid = 4'hF; in_dst = 8'h55; free_regs = 4'd5; settle();
    check("R1 retry first", 32'(retry_go), 1);
    check("R1 slots after retry", 32'({slot_taken, slot_dispatch}), 32'h73);
    check("R8 regs with retry", 32'(regs_used), 5);
    next(); in_valid = 4'hF; in_dst = 8'h55; settle();
    check("R2 restall", 32'({buf_valid, stop}), 32'h3);
    check("R3 retry then full group", 32'({retry_go, slot_dispatch}), 32'h1F);
    check("R8 regs full", 32'(regs_used), 5);
    next(); settle();
    check("R3 stop clears", 32'({buf_valid, stop}), 0);

    next(); in_valid = 4'hF; in_br = 4'h2; in_taken = 4'h2; settle();
    check("R4 taken cuts", 32'({slot_taken, slot_dispatch}), 32'h33);
    next(); in_valid = 4'hF; settle();
    check("R4 resumes", 32'({stop, slot_taken}), 32'h0F);

    next(); in_valid = 4'h3; in_br = 4'h1; in_delayed = 4'h1; free_shadow = 4'd0; settle();
    check("R5 no shadow parks", 32'({slot_taken, slot_dispatch}), 32'h31);
    next(); free_shadow = 4'd1; settle();
    check("R5 retry gets shadow", 32'({retry_go, shadow_used}), 32'h11);
    next(); in_valid = 4'hF; in_br = 4'h8; in_taken = 4'h8; in_delayed = 4'h8; settle();
    check("R5 branch last", 32'({slot_dispatch, shadow_used}), 32'hF0);
    next(); in_valid = 4'h1; free_shadow = 4'd1; settle();
    check("R5 carried need", 32'({slot_dispatch, shadow_used}), 32'h11);
    next(); in_valid = 4'hF; free_shadow = 4'd0; settle();
    check("R5 need consumed", 32'({slot_dispatch, shadow_used}), 32'hF0);

    next(); in_valid = 4'hF; in_br = 4'h2; in_unpred = 4'h2; in_annul = 4'h2; in_delayed = 4'h2; settle();
    check("R6 annul stops at branch", 32'({slot_taken, slot_dispatch}), 32'h33);
    next(); in_valid = 4'hF; settle();
    check("R6 held", 32'({stop, slot_taken}), 32'h10);
    next(); in_valid = 4'hF; free_regs = 4'd15; settle();
    check("R6 still held", 32'({stop, slot_taken}), 32'h10);
    do_flush();
    check("R9 flush releases", 32'({stop, slot_taken}), 0);
    next(); in_valid = 4'hF; in_br = 4'h2; in_unpred = 4'h2; in_delayed = 4'h2; settle();
    check("R6 delay slot passes", 32'({slot_taken, slot_dispatch}), 32'h77);
    next(); settle();
    check("R6 stop after slot", 32'(stop), 1);
    do_flush();
    next(); in_valid = 4'hF; in_br = 4'h8; in_unpred = 4'h8; in_delayed = 4'h8; settle();
    check("R6 branch in last slot", 32'(slot_taken), 32'hF);
    next(); in_valid = 4'hF; settle();
    check("R6 one slot next cycle", 32'({stop, slot_taken}), 32'h01);
    next(); in_valid = 4'hF; settle();
    check("R6 stop after carry", 32'({stop, slot_taken}), 32'h10);
    do_flush();

    next(); in_valid = 4'hF; in_mem = 4'h3; free_memq = 4'd1; static_mode = 1'b1; settle();
    check("R7 static parks", 32'({slot_taken, slot_dispatch}), 32'h31);
    check("R7 memq used", 32'(memq_used), 1);
    do_flush();
    next(); in_valid = 4'hF; in_mem = 4'h3; free_memq = 4'd1; static_mode = 1'b0; settle();
    check("R7 dynamic overflow", 32'({slot_dispatch, slot_ovf}), 32'hF2);
    check("R7 ovf no memq", 32'(memq_used), 1);

    next(); in_valid = 4'h5; settle();
    check("R10 gap ends group", 32'(slot_taken), 32'h1);

    next();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule